// File: doc/BRIEF.md
# Mixed-Precision SIMD Multiply-Accumulate Issue Controller

This block decides when operations may enter a SIMD multiply-accumulate engine that has two timing regimes, and when each one's result comes back. Single-precision work spans four lanes on a fully pipelined path and may start every cycle. Double-precision work spans two lanes on a path that is not pipelined: once a double-precision operation starts, no other double-precision operation may start until the full latency has passed. The arithmetic is not modelled here. The block tracks occupancy, write-back slots and the order of completions, and returns each operation's tag, precision and lane mask in its write-back cycle.

A requester presents `req_valid`, a precision bit `req_dp` (0 = single, 1 = double) and a tag. `req_ready` is a combinational answer for the request currently presented, and an operation is accepted in any cycle where `req_valid` and `req_ready` are both high. A 7-entry completion register records which future cycles already hold a write-back. Any request whose write-back would land in an occupied cycle is stalled, so that at most one result is written back per cycle. With the default equal latencies, results leave in issue order. The latencies are parameters, so a build with unequal latencies uses the same stall rule to avoid write-back collisions.

Top module: `mac_issue_ctrl`

## Requirements
- R1: A single-precision operation accepted in cycle c gives `res_valid`=1 in cycle c+7 exactly, with its tag, `res_dp`=0 and `res_lane_en`=4'b1111.
- R2: With no double-precision work pending, single-precision requests see `req_ready`=1 in every cycle and may be accepted back to back.
- R3: A double-precision operation accepted in cycle c gives `res_valid`=1 in cycle c+7 exactly, with its tag, `res_dp`=1 and `res_lane_en`=4'b0011 (the lower two lanes).
- R4: After a double-precision acceptance in cycle c, `req_ready` is 0 for double-precision requests in cycles c+1 to c+6 and 1 again in cycle c+7. Two double-precision acceptances are never closer than 7 cycles apart.
- R5: Single-precision requests are accepted while the double-precision path is busy.
- R6: A request whose write-back cycle is already taken sees `req_ready`=0. In a build with a single-precision latency of 5, a single-precision request two cycles after a double-precision acceptance is stalled. Requests one and three cycles after it are accepted.
- R7: At most one result is written back per cycle. Each result returns its own tag unchanged, in completion order.
- R8: Reset clears the busy state and all pending completions. During reset, `res_valid`=0 and `res_lane_en`=0. Operations accepted before a reset never appear. Right after reset release, `req_ready`=1 for both precisions.
- R9: A cycle with `req_valid`=0 starts nothing: no result appears in any later cycle because of it. When `res_valid`=0, `res_lane_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Issue request present |
| req_dp | input | 1 | Request precision: 0 single, 1 double |
| req_tag | input | TAG_W | Tag carried by the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| res_valid | output | 1 | Write-back this cycle |
| res_dp | output | 1 | Precision of the written-back operation |
| res_tag | output | TAG_W | Tag of the written-back operation |
| res_lane_en | output | LANES | Lanes written this cycle |

## Verification
The bench targets the edges of the double-precision busy window. A counter that is off by one either accepts a second double-precision operation at six cycles, which the spacing check reports, or holds ready low into the seventh cycle, which the directed ready checks report. Every accepted tag is scheduled in a bench model for its exact write-back cycle. A latency or ordering error therefore shows up as a result early, late, missing or carrying the wrong tag, and a lost idle-cycle gate shows up as a spurious result. A second instance with a shorter single-precision latency exposes a missing slot-collision stall, which would let two results land in one cycle. A reset in the middle of traffic checks that stale completions and a stale busy count are cleared.

// File: rtl/mac_issue_pkg.sv
package mac_issue_pkg;

  typedef enum logic {
    PREC_SINGLE = 1'b0,
    PREC_DOUBLE = 1'b1
  } prec_e;

  function automatic int lat_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/mac_dp_occupancy.sv
module mac_dp_occupancy #(
  parameter int II = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = (II > 1) ? $clog2(II + 1) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign busy   = (cnt_q != '0);
  assign cnt_en = start | busy;

  always_comb begin
    cnt_d = cnt_q;
    if (start)     cnt_d = CW'(II - 1);
    else if (busy) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/mac_wb_ring.sv
module mac_wb_ring #(
  parameter int TAG_W  = 4,
  parameter int SP_LAT = 7,
  parameter int DP_LAT = 7,
  parameter int DEPTH  = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_dp,
  input  logic [TAG_W-1:0] push_tag,
  output logic             sp_free,
  output logic             dp_free,
  output logic             out_valid,
  output logic             out_dp,
  output logic [TAG_W-1:0] out_tag
);
  logic [DEPTH-1:0]            vld_q, vld_d;
  logic [DEPTH-1:0]            dp_q, dp_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic                        ring_en;

  // A new entry lands at index LAT-1 after this edge; the entry now at
  // index LAT would shift there, so that index decides the slot.
  generate
    if (SP_LAT < DEPTH) begin : g_sp_chk
      assign sp_free = ~vld_q[SP_LAT];
    end else begin : g_sp_top
      assign sp_free = 1'b1;
    end
    if (DP_LAT < DEPTH) begin : g_dp_chk
      assign dp_free = ~vld_q[DP_LAT];
    end else begin : g_dp_top
      assign dp_free = 1'b1;
    end
  endgenerate

  assign ring_en = push | (vld_q != '0);

  always_comb begin
    vld_d = vld_q >> 1;
    dp_d  = dp_q >> 1;
    tag_d = tag_q >> TAG_W;
    if (push) begin
      if (push_dp) begin
        vld_d[DP_LAT-1] = 1'b1;
        dp_d[DP_LAT-1]  = 1'b1;
        tag_d[DP_LAT-1] = push_tag;
      end else begin
        vld_d[SP_LAT-1] = 1'b1;
        dp_d[SP_LAT-1]  = 1'b0;
        tag_d[SP_LAT-1] = push_tag;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dp_q  <= '0;
      tag_q <= '0;
    end else if (ring_en) begin
      vld_q <= vld_d;
      dp_q  <= dp_d;
      tag_q <= tag_d;
    end
  end

  assign out_valid = vld_q[0];
  assign out_dp    = dp_q[0];
  assign out_tag   = tag_q[0];
endmodule

// File: rtl/mac_lane_mask.sv
module mac_lane_mask #(
  parameter int LANES = 4
) (
  input  logic             valid,
  input  logic             dp,
  output logic [LANES-1:0] lane_en
);
  localparam int DP_LANES = LANES / 2;

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (l < DP_LANES) begin : g_shared
        assign lane_en[l] = valid;
      end else begin : g_sp_only
        assign lane_en[l] = valid & ~dp;
      end
    end
  endgenerate
endmodule

// File: rtl/mac_issue_ctrl.sv
module mac_issue_ctrl
  import mac_issue_pkg::*;
#(
  parameter int TAG_W  = 4,
  parameter int LANES  = 4,
  parameter int SP_LAT = 7,
  parameter int DP_LAT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_dp,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             res_valid,
  output logic             res_dp,
  output logic [TAG_W-1:0] res_tag,
  output logic [LANES-1:0] res_lane_en
);
  localparam int DEPTH = lat_max(SP_LAT, DP_LAT);
  localparam int DP_II = DP_LAT;

  prec_e req_prec;
  logic  dp_busy, sp_free, dp_free, fire, dp_start;

  assign req_prec  = prec_e'(req_dp);
  assign req_ready = (req_prec == PREC_DOUBLE) ? (~dp_busy & dp_free) : sp_free;
  assign fire      = req_valid & req_ready;
  assign dp_start  = fire & (req_prec == PREC_DOUBLE);

  mac_dp_occupancy #(.II(DP_II)) u_occ (
    .clk   (clk),
    .rst_n (rst_n),
    .start (dp_start),
    .busy  (dp_busy)
  );

  mac_wb_ring #(
    .TAG_W (TAG_W),
    .SP_LAT(SP_LAT),
    .DP_LAT(DP_LAT),
    .DEPTH (DEPTH)
  ) u_ring (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (fire),
    .push_dp  (req_dp),
    .push_tag (req_tag),
    .sp_free  (sp_free),
    .dp_free  (dp_free),
    .out_valid(res_valid),
    .out_dp   (res_dp),
    .out_tag  (res_tag)
  );

  mac_lane_mask #(.LANES(LANES)) u_lanes (
    .valid  (res_valid),
    .dp     (res_dp),
    .lane_en(res_lane_en)
  );
endmodule

// File: rtl/mac_issue_ctrl_chk.sv
module mac_issue_ctrl_chk #(
  parameter int LANES  = 4,
  parameter int SP_LAT = 7,
  parameter int DP_LAT = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_dp,
  input logic             req_ready,
  input logic             res_valid,
  input logic [LANES-1:0] res_lane_en
);
  localparam int DEPTH   = (SP_LAT > DP_LAT) ? SP_LAT : DP_LAT;
  localparam int MIN_LAT = (SP_LAT < DP_LAT) ? SP_LAT : DP_LAT;
  localparam int GW      = $clog2(DEPTH + 2) + 1;

  logic          fire, dp_fire;
  logic [GW-1:0] gap_cnt, since_rst, outstanding;

  assign fire    = req_valid & req_ready;
  assign dp_fire = fire & req_dp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt     <= GW'(DP_LAT);
      since_rst   <= '0;
      outstanding <= '0;
    end else begin
      if (dp_fire)                  gap_cnt <= GW'(1);
      else if (gap_cnt < GW'(DP_LAT)) gap_cnt <= gap_cnt + 1'b1;
      if (since_rst < GW'(DEPTH + 1)) since_rst <= since_rst + 1'b1;
      outstanding <= outstanding + GW'(fire) - GW'(res_valid);
    end
  end

  AST_DP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    dp_fire |-> (gap_cnt >= GW'(DP_LAT))); // R4

  AST_DP_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    dp_fire |=> !(req_dp && req_ready)); // R4

  AST_RESULT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst < GW'(MIN_LAT)) |-> !res_valid); // R8

  AST_OUTSTANDING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= GW'(DEPTH)); // R7

  AST_LANES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (res_lane_en == '0)); // R9
endmodule

bind mac_issue_ctrl mac_issue_ctrl_chk #(
  .LANES (LANES),
  .SP_LAT(SP_LAT),
  .DP_LAT(DP_LAT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_dp     (req_dp),
  .req_ready  (req_ready),
  .res_valid  (res_valid),
  .res_lane_en(res_lane_en)
);

// File: tb/mac_issue_ctrl_test.sv
`timescale 1ns/1ps
module mac_issue_ctrl_test;
  localparam int TW  = 4;
  localparam int LAT = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_dp, req_ready, res_valid, res_dp;
  logic [TW-1:0] req_tag, res_tag;
  logic [3:0]    res_lane_en;
  logic s_valid, s_dp, s_ready, s_res_valid, s_res_dp;
  logic [TW-1:0] s_tag, s_res_tag;
  logic [3:0]    s_lanes;

  int checks = 0, errors = 0, cyc = 0, res_seen = 0, last_dp = -100;
  bit  exp_v [64];
  int  exp_tag [64];
  bit  exp_dp [64];

  always #10 clk = ~clk;

  mac_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dp(req_dp),
    .req_tag(req_tag), .req_ready(req_ready), .res_valid(res_valid),
    .res_dp(res_dp), .res_tag(res_tag), .res_lane_en(res_lane_en));

  mac_issue_ctrl #(.SP_LAT(5)) uut_skew (
    .clk(clk), .rst_n(rst_n), .req_valid(s_valid), .req_dp(s_dp),
    .req_tag(s_tag), .req_ready(s_ready), .res_valid(s_res_valid),
    .res_dp(s_res_dp), .res_tag(s_res_tag), .res_lane_en(s_lanes));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: samples 5 ns after the falling edge, before the next rising edge.
  always @(negedge clk) begin
    #5;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
      last_dp = -100;
      chk(res_valid == 1'b0, "R8 res_valid in reset", res_valid, 0);
      chk(res_lane_en == 4'b0, "R8 lanes in reset", res_lane_en, 0);
    end else begin
      int s;
      s = cyc % 64;
      if (res_valid) res_seen++;
      if (exp_v[s] || res_valid) begin
        chk(res_valid == exp_v[s], "R1/R3/R9 result cycle", res_valid, exp_v[s]);
        if (exp_v[s] && res_valid) begin
          chk(res_tag == exp_tag[s][TW-1:0], "R7 tag", res_tag, exp_tag[s]);
          chk(res_dp == exp_dp[s], "R1/R3 precision", res_dp, exp_dp[s]);
          chk(res_lane_en == (exp_dp[s] ? 4'b0011 : 4'b1111), "R1/R3 lanes",
              res_lane_en, exp_dp[s] ? 3 : 15);
        end
      end else begin
        chk(res_lane_en == 4'b0, "R9 idle lanes", res_lane_en, 0);
      end
      exp_v[s] = 1'b0;
      if (req_valid && req_ready) begin
        int e;
        e = (cyc + LAT) % 64;
        exp_v[e] = 1'b1;
        exp_tag[e] = int'(req_tag);
        exp_dp[e] = req_dp;
        if (req_dp) begin
          chk(cyc - last_dp >= LAT, "R4 dp spacing", cyc - last_dp, LAT);
          last_dp = cyc;
        end
      end
    end
    cyc++;
  end

  task automatic drive(input bit v, input bit dp, input int tag);
    @(negedge clk);
    req_valid = v;
    req_dp = dp;
    req_tag = tag[TW-1:0];
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(1'b0, 1'b1, 0);
    #5 chk(req_ready == 1'b1, "R8 dp ready after reset", req_ready, 1);
    drive(1'b0, 1'b0, 0);
    #5 chk(req_ready == 1'b1, "R8 sp ready after reset", req_ready, 1);
  endtask

  task automatic t_sp_stream;
    for (int i = 0; i < 10; i++) begin
      drive(1'b1, 1'b0, i);
      #5 chk(req_ready == 1'b1, "R2 sp back to back", req_ready, 1);
    end
    idle(10);
  endtask

  task automatic t_dp_spacing;
    drive(1'b1, 1'b1, 3);
    #5 chk(req_ready == 1'b1, "R4 first dp ready", req_ready, 1);
    for (int i = 1; i <= 7; i++) begin
      drive(1'b1, 1'b1, 3 + i);
      #5 chk(req_ready == (i == 7), "R4 dp busy window", req_ready, (i == 7));
    end
    idle(10);
  endtask

  task automatic t_sp_during_dp;
    drive(1'b1, 1'b1, 9);
    for (int i = 1; i <= 6; i++) begin
      drive(1'b1, 1'b0, 9 + i);
      #5 chk(req_ready == 1'b1, "R5 sp while dp busy", req_ready, 1);
    end
    idle(10);
  endtask

  task automatic t_idle_ignored;
    int base;
    base = res_seen;
    for (int i = 0; i < 12; i++) drive(1'b0, i[0], i);
    idle(8);
    chk(res_seen == base, "R9 idle requests ignored", res_seen - base, 0);
  endtask

  task automatic t_random_mix;
    for (int i = 0; i < 400; i++) drive($urandom_range(0, 3) != 0, $urandom_range(0, 2) == 0, i);
    idle(10);
  endtask

  task automatic t_mid_reset;
    int base;
    drive(1'b1, 1'b1, 5);
    drive(1'b1, 1'b0, 6);
    drive(1'b1, 1'b0, 7);
    @(negedge clk);
    req_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    base = res_seen;
    req_valid = 1'b1;
    req_dp = 1'b1;
    req_tag = 4'd2;
    #5 chk(req_ready == 1'b1, "R8 busy cleared by reset", req_ready, 1);
    idle(12);
    chk(res_seen == base + 1, "R8 stale results dropped", res_seen - base, 1);
  endtask

  task automatic t_skew_collision;
    for (int i = 0; i <= 10; i++) begin
      @(negedge clk);
      s_valid = (i <= 3 && i != 0) || i == 0;
      s_dp = (i == 0);
      s_tag = TW'(i + 1);
      if (i > 3) s_valid = 1'b0;
      #5;
      if (i <= 3) chk(s_ready == (i != 2), "R6 collision stall", s_ready, (i != 2));
      chk(s_res_valid == (i == 6 || i == 7 || i == 8), "R6 skew result cycle",
          s_res_valid, (i == 6 || i == 7 || i == 8));
      if (i == 6) chk(s_res_tag == 4'd2 && !s_res_dp, "R6 sp first", s_res_tag, 2);
      if (i == 7) chk(s_res_tag == 4'd1 && s_res_dp, "R6 dp second", s_res_tag, 1);
      if (i == 8) chk(s_res_tag == 4'd4 && !s_res_dp, "R6 sp third", s_res_tag, 4);
    end
    s_valid = 1'b0;
  endtask

  bit done = 1'b0;

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_dp = 1'b0; req_tag = '0;
    s_valid = 1'b0; s_dp = 1'b0; s_tag = '0;
    t_reset();
    t_sp_stream();
    t_dp_spacing();
    t_sp_during_dp();
    t_idle_ignored();
    t_random_mix();
    t_mid_reset();
    t_skew_collision();
    idle(4);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule